// File: doc/BRIEF.md
# Set-Associative Tag Lookup

This block keeps the tag, valid and dirty state for every way of an n-way set-associative cache; the default is two ways. A lookup address is cut into tag, set and byte-offset fields. The set field equals the memory block number modulo the number of sets, and it selects one row. The tags of all ways in that row are then compared at the same time. A way can match only while its valid bit is set. The result comes back one clock after the request. It gives a hit flag, the number of the hitting way, and whether that way already held modified data.

A fill port installs a new tag. It takes the way picked by an external replacement selector, marks that way valid and clean. A lookup that is flagged as a write and hits marks the hitting way dirty. A synchronous clear empties the whole array. The data array sits beside this block and is indexed with the set number and the way number returned here.

The widths come from the cache size, the line size and the number of ways. If the ways are doubled at a fixed size, the number of sets halves, the set field loses one bit and the tag gains one. The defaults keep the array small: 4 KiB, 32-byte lines, 2 ways, 64 sets.

Top module: `sa_tag_lookup`

## Requirements
- R1: With the default geometry, a 32-bit address decodes as follows. The byte offset is bits [4:0] and is ignored by the lookup. The set number is bits [10:5], which is the block number modulo 64. The tag is bits [31:11].
- R2: `rsp_valid` is high in exactly the cycle that follows a cycle with `lk_req` high.
- R3: `rsp_hit` is high only when some way of the addressed set is valid and holds the address tag. In that case `rsp_way` gives the number of that way. Ways in other sets never produce a hit.
- R4: A fill writes the tag of `fill_addr` into way `fill_way` of its set, sets that way valid and clears its dirty bit. Lookups requested from the next cycle on see the new entry.
- R5: A lookup requested in the same cycle as a fill, a clear or a dirty update is judged against the array state from before that clock edge.
- R6: A lookup with `lk_wr` high that hits sets the dirty bit of the hitting way. `rsp_dirty` reports that way's dirty bit as it was before the request, and it is 0 on a miss.
- R7: `clear` invalidates and cleans every way of every set at the next edge. It takes priority over a fill and a dirty update in the same cycle.
- R8: After reset `rsp_valid` is 0 and every way is invalid, so the first lookup misses.
- R9: When more than one way of a set matches, `multi_hit` is high together with `rsp_hit`, and `rsp_way` names the lowest-numbered matching way.
- R10: While `rsp_valid` is low, `rsp_hit`, `rsp_dirty` and `multi_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Invalidate the whole array |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_wr | input | 1 | Lookup is a write; a hit makes the way dirty |
| fill_en | input | 1 | Install a tag |
| fill_addr | input | ADDR_W | Address of the block being installed |
| fill_way | input | WAY_W | Way chosen by the replacement selector |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | A valid way matched |
| rsp_way | output | WAY_W | Number of the matching way |
| rsp_dirty | output | 1 | Matching way held modified data before the request |
| multi_hit | output | 1 | More than one way matched |

## Verification
The timing corner is a lookup and an array update that land on the same clock edge. The update can be a fill to the looked-up block, a write hit, or a clear. The bench drives each of these pairs in one cycle, on purpose. It expects the response to reflect the old contents, and it expects the following lookup to show the new ones. A random phase draws addresses from a few tags and sets, so that fills, write hits, clears and lookups often meet on the same row. A bench model advances the array after every edge and supplies the expected values.

// File: rtl/sa_tag_pkg.sv
package sa_tag_pkg;

    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_LINE_BYTES  = 32;
    localparam int DEF_CACHE_BYTES = 4096;
    localparam int DEF_WAYS        = 2;

    // Array update chosen for one edge, highest priority first.
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_FILL  = 2'd2
    } upd_kind_e;

    function automatic int sets_of(int cache_bytes, int line_bytes, int ways);
        return cache_bytes / (line_bytes * ways);
    endfunction

    function automatic int idx_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sa_addr_split.sv
module sa_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5,
    parameter int SET_W  = 6,
    parameter int TAG_W  = ADDR_W - OFS_W - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    // The set field is the low part of the block number, i.e. block mod sets.
    assign set_idx = addr[OFS_W +: SET_W];
    assign tag     = addr[ADDR_W-1 -: TAG_W];

    logic unused_offset;
    assign unused_offset = ^addr[OFS_W-1:0];
endmodule

// File: rtl/sa_way_store.sv
module sa_way_store
    import sa_tag_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int SET_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_kind_e        upd,
    input  logic             upd_sel,
    input  logic [SET_W-1:0] upd_set,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             mark_en,
    input  logic [SET_W-1:0] mark_set,
    input  logic [SET_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic             fill_here;

    assign fill_here = (upd == UPD_FILL) && upd_sel;

    always_ff @(posedge clk) begin
        if (fill_here) begin
            tag_q[upd_set] <= upd_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || upd == UPD_CLEAR) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (mark_en) begin
                dirty_q[mark_set] <= 1'b1;
            end
            if (fill_here) begin
                valid_q[upd_set] <= 1'b1;
                dirty_q[upd_set] <= 1'b0;
            end
        end
    end

    assign rd_tag   = tag_q[rd_set];
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];

    // R7: a clear leaves no valid entry behind
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (upd == UPD_CLEAR) |=> (valid_q == '0 && dirty_q == '0));

    // R4: a fill leaves its row valid and clean
    a_r4_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
        fill_here |=> (valid_q[$past(upd_set)] && !dirty_q[$past(upd_set)]));
endmodule

// File: rtl/sa_match.sv
module sa_match #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1,
    parameter int TAG_W = 21
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0]            way_dirty,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       hit_dirty,
    output logic                       multi
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_way   = '0;
        hit_dirty = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit_way   = WAY_W'(w);
                hit_dirty = way_dirty[w];
            end
        end
    end

    assign hit   = |eq;
    assign multi = ($countones(eq) > 1);
endmodule

// File: rtl/sa_tag_lookup.sv
module sa_tag_lookup
    import sa_tag_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int LINE_BYTES  = DEF_LINE_BYTES,
    parameter int CACHE_BYTES = DEF_CACHE_BYTES,
    parameter int WAYS        = DEF_WAYS,
    localparam int SETS  = sets_of(CACHE_BYTES, LINE_BYTES, WAYS),
    localparam int OFS_W = $clog2(LINE_BYTES),
    localparam int SET_W = idx_bits(SETS),
    localparam int TAG_W = ADDR_W - OFS_W - SET_W,
    localparam int WAY_W = idx_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_wr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WAY_W-1:0]  fill_way,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_dirty,
    output logic              multi_hit
);
    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    upd_kind_e        upd;

    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            rd_valid, rd_dirty;

    logic             m_hit, m_dirty, m_multi;
    logic [WAY_W-1:0] m_way;

    sa_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SET_W(SET_W), .TAG_W(TAG_W))
        i_split_lk (.addr(lk_addr), .set_idx(lk_set), .tag(lk_tag));

    sa_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SET_W(SET_W), .TAG_W(TAG_W))
        i_split_fl (.addr(fill_addr), .set_idx(fl_set), .tag(fl_tag));

    always_comb begin
        if (clear)        upd = UPD_CLEAR;
        else if (fill_en) upd = UPD_FILL;
        else              upd = UPD_IDLE;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic sel_w, mark_w;
        assign sel_w  = (fill_way == WAY_W'(w));
        assign mark_w = lk_req && lk_wr && m_hit && (m_way == WAY_W'(w));

        sa_way_store #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) i_store (
            .clk      (clk),
            .rst      (rst),
            .upd      (upd),
            .upd_sel  (sel_w),
            .upd_set  (fl_set),
            .upd_tag  (fl_tag),
            .mark_en  (mark_w),
            .mark_set (lk_set),
            .rd_set   (lk_set),
            .rd_tag   (rd_tag[w]),
            .rd_valid (rd_valid[w]),
            .rd_dirty (rd_dirty[w])
        );
    end

    sa_match #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) i_match (
        .way_tag   (rd_tag),
        .way_valid (rd_valid),
        .way_dirty (rd_dirty),
        .req_tag   (lk_tag),
        .hit       (m_hit),
        .hit_way   (m_way),
        .hit_dirty (m_dirty),
        .multi     (m_multi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_dirty <= 1'b0;
            multi_hit <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && m_hit;
            rsp_way   <= lk_req ? m_way : '0;
            rsp_dirty <= lk_req && m_dirty;
            multi_hit <= lk_req && m_multi;
        end
    end

    // R2: one response per request, one cycle later
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);
    a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);
    // R10: nothing is reported without a response
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_dirty && !multi_hit));
    // R9: multiple matches are still a hit
    a_r9_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> rsp_hit);
    // R6: a dirty report belongs to a hitting way
    a_r6_dirty_needs_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_dirty |-> rsp_hit);
endmodule

// File: tb/test_sa_tag_lookup.sv
module test_sa_tag_lookup;
    logic        clk = 1'b0;
    logic        rst, clear, lk_req, lk_wr, fill_en;
    logic [31:0] lk_addr, fill_addr;
    logic        fill_way;
    logic        rsp_valid, rsp_hit, rsp_dirty, multi_hit;
    logic        rsp_way;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [20:0] m_tag [64][2];
    bit          m_val [64][2];
    bit          m_dty [64][2];

    always #10 clk = ~clk;

    sa_tag_lookup i_sa_tag_lookup (
        .clk(clk), .rst(rst), .clear(clear), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_wr(lk_wr), .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_dirty(rsp_dirty), .multi_hit(multi_hit)
    );

    // R1 field positions
    function automatic int f_set(logic [31:0] a);
        return int'(a[10:5]);
    endfunction
    function automatic logic [20:0] f_tag(logic [31:0] a);
        return a[31:11];
    endfunction

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 64; s++) begin
            for (int w = 0; w < 2; w++) begin
                m_val[s][w] = 0;
                m_dty[s][w] = 0;
            end
        end
    endtask

    // One cycle: drive, predict from the pre-edge model, advance model, check.
    task automatic step(logic req, logic [31:0] a, logic wr, logic fil,
                        logic [31:0] fa, logic fw, logic clr, string rq);
        bit e_hit, e_dty, e_multi;
        bit e_way;
        int n, s;
        lk_req = req; lk_addr = a; lk_wr = wr;
        fill_en = fil; fill_addr = fa; fill_way = fw; clear = clr;
        s = f_set(a);
        n = 0; e_way = 0; e_dty = 0;
        for (int w = 1; w >= 0; w--) begin
            if (m_val[s][w] && m_tag[s][w] == f_tag(a)) begin
                n++;
                e_way = w[0];
                e_dty = m_dty[s][w];
            end
        end
        e_hit   = req && (n > 0);
        e_multi = req && (n > 1);
        e_dty   = e_hit && e_dty;
        if (!req) e_way = 0;
        @(posedge clk);
        if (clr) begin
            model_clear();
        end else begin
            if (req && wr && e_hit) m_dty[s][e_way] = 1;
            if (fil) begin
                m_tag[f_set(fa)][fw] = f_tag(fa);
                m_val[f_set(fa)][fw] = 1;
                m_dty[f_set(fa)][fw] = 0;
            end
        end
        @(negedge clk);
        check("R2", "rsp_valid", rsp_valid, req);
        check(rq, "rsp_hit", rsp_hit, e_hit);
        if (e_hit) check("R3", "rsp_way", rsp_way, e_way);
        check("R6", "rsp_dirty", rsp_dirty, e_dty);
        check("R9", "multi_hit", multi_hit, e_multi);
        lk_req = 0; fill_en = 0; clear = 0; lk_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] A, B;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        rst = 1; clear = 0; lk_req = 0; lk_addr = 0; lk_wr = 0;
        fill_en = 0; fill_addr = 0; fill_way = 0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "rsp_valid in reset", rsp_valid, 0);
        rst = 0;
        step(1, 32'h0, 0, 0, 0, 0, 0, "R8");           // empty array misses

        A = 32'hA035_F014;
        step(0, 0, 0, 1, A, 0, 0, "R10");              // fill way 0, idle lookup
        step(1, A, 0, 0, 0, 0, 0, "R4");               // hit way 0
        step(1, A ^ 32'h1F, 0, 0, 0, 0, 0, "R1");      // other offset, same block
        step(1, A + 32'h20, 0, 0, 0, 0, 0, "R1");      // next set misses
        step(1, A ^ 32'h8000_0000, 0, 0, 0, 0, 0, "R3"); // same set, other tag

        B = A ^ 32'h4000_0000;
        step(1, B, 0, 1, B, 1, 0, "R5");               // fill and lookup together: miss
        step(1, B, 0, 0, 0, 0, 0, "R4");               // now hit way 1
        step(1, B, 1, 0, 0, 0, 0, "R6");               // write hit, prior clean
        step(1, B, 0, 0, 0, 0, 0, "R6");               // now dirty
        step(1, B, 0, 1, B, 1, 0, "R5");               // refill same cycle sees dirty
        step(1, B, 0, 0, 0, 0, 0, "R4");               // refill cleaned it

        step(1, A, 0, 1, B, 0, 1, "R5");               // clear+fill+lookup: old state hit
        step(1, A, 0, 0, 0, 0, 0, "R7");               // cleared
        step(1, B, 0, 0, 0, 0, 0, "R7");               // fill lost to clear

        step(0, 0, 0, 1, A, 0, 0, "R10");
        step(0, 0, 0, 1, A, 1, 0, "R10");
        step(1, A, 1, 0, 0, 0, 0, "R9");               // both ways match, way 0
        step(1, A, 0, 0, 0, 0, 0, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, fa;
            ra = {$urandom_range(3, 0) << 29, 18'h0, 3'($urandom_range(3, 0)), 5'($urandom)} |
                 ($urandom_range(3, 0) << 5) | ($urandom & 32'h0000_0000);
            fa = {$urandom_range(3, 0) << 29, 18'h0, 3'($urandom_range(3, 0)), 5'($urandom)} |
                 ($urandom_range(3, 0) << 5);
            step($urandom_range(9, 0) < 7, ra, $urandom_range(1, 0) == 1,
                 $urandom_range(9, 0) < 3, fa, $urandom_range(1, 0) == 1,
                 $urandom_range(99, 0) == 0, "R3");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule